// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

A 16-bit up-counter with two compare channels, A and B, for the non-PWM waveform modes only. In free-running mode the counter rolls over from its maximum value to zero and emits a one-cycle overflow strobe. In clear-on-match mode it returns to zero after it reaches the channel A compare value. Each channel compares the count with its own compare register. On a match, the channel's 2-bit output mode decides whether its registered compare level toggles, is cleared or is set, or whether it is left alone.

Each channel owns one pin. A nonzero output mode routes the compare level onto the pin in place of the general-purpose port value. The pin's output enable always follows the port's direction bit. The counter advances on every clock, or on every eighth clock when the divider is selected. All configuration is loaded through a byte-wide write port.

Top module: `tmr_cmp_wave`

## Requirements
- R1: While rst_ni is low and right after its release, cnt_o is 0, ovf_o is 0, both compare levels are 0, all register fields are 0 and pin_o equals port_out_i.
- R2: With divider select (address 1, bit 0) at 0, cnt_o advances by one on every clock. With it at 1, cnt_o advances once every 8 clocks, so 80 clocks give exactly 10 steps.
- R3: In free-running mode the count wraps from 0xFFFF to 0. ovf_o is high for exactly the one clock in which cnt_o has just become 0 through that wrap, and it never rises in clear-on-match mode.
- R4: Clear-on-match mode is selected when the waveform code {addr1[2:1], addr0[1:0]} equals 4'b0100. In this mode, on the step after cnt_o equals the channel A compare value, cnt_o becomes 0.
- R5: Output mode 01 inverts the channel's compare level on each advancing step in which cnt_o equals that channel's compare value.
- R6: Output mode 10 drives the compare level to 0 on a match, and mode 11 drives it to 1.
- R7: With output mode 00, pin_o of that channel equals port_out_i, and matches leave the internal compare level unchanged.
- R8: Writing an output mode does not alter the compare level. A newly connected pin shows the stored level until the next match.
- R9: With a nonzero output mode, pin_o shows the compare level whatever port_out_i is. pin_oe_o always equals port_dir_i.
- R10: Any waveform code other than 4'b0100 behaves as free-running mode, and the count passes the channel A compare value without clearing.
- R11: The write port decodes the following. Address 0 holds the channel A mode in bits 7:6, the channel B mode in bits 5:4 and the waveform code's low bits in bits 1:0. Address 1 holds the divider select in bit 0 and the waveform code's high bits in bits 2:1. Addresses 2/3 hold the low/high bytes of compare A, and addresses 4/5 hold the low/high bytes of compare B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| port_out_i | input | 2 | General-purpose port value per pin (bit 0 = A) |
| port_dir_i | input | 2 | Direction bit per pin, 1 = drive |
| pin_o | output | 2 | Pin value after the compare/port mux |
| pin_oe_o | output | 2 | Pin output enable |
| cnt_o | output | 16 | Current count |
| ovf_o | output | 1 | One-cycle overflow strobe |

## Verification
Three events can fall on the same advancing step: a compare match on either channel, the counter clear in clear-on-match mode, and the rollover with its overflow strobe. The bench forces the first coincidence by setting both compare values to 0xFFFF in free-running mode, so both channels act on the very step that wraps the count and raises ovf_o. It forces the second by giving channel B the same value as channel A in clear-on-match mode. A behavioural reference model predicts count, strobe, pins and enables on every clock. These cycles are judged by the rule that the action and the counter update both use the count value present before that step.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;
  typedef enum logic [1:0] {
    COM_OFF    = 2'b00,
    COM_TOGGLE = 2'b01,
    COM_CLEAR  = 2'b10,
    COM_SET    = 2'b11
  } com_e;

  localparam int unsigned N_CH          = 2;
  localparam logic [3:0]  WGM_CTC       = 4'b0100;
  localparam int unsigned ADDR_CTRL_A   = 0;
  localparam int unsigned ADDR_CTRL_B   = 1;
  localparam int unsigned ADDR_OCR_BASE = 2;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_cmp_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [7:0]                       wr_data_i,
  output logic [N_CH-1:0][1:0]             com_o,
  output logic [3:0]                       wgm_o,
  output logic                             div8_o,
  output logic [N_CH-1:0][CNT_W-1:0]       ocr_o
);
  localparam int unsigned NBYTES = CNT_W / 8;

  logic [1:0]                       com_a_q, com_b_q, wgm_lo_q, wgm_hi_q;
  logic                             div8_q;
  logic [N_CH-1:0][CNT_W-1:0]       ocr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      com_a_q  <= '0;
      com_b_q  <= '0;
      wgm_lo_q <= '0;
      wgm_hi_q <= '0;
      div8_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_CTRL_A)) begin
        com_a_q  <= wr_data_i[7:6];
        com_b_q  <= wr_data_i[5:4];
        wgm_lo_q <= wr_data_i[1:0];
      end
      if (wr_addr_i == ADDR_W'(ADDR_CTRL_B)) begin
        div8_q   <= wr_data_i[0];
        wgm_hi_q <= wr_data_i[2:1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < int'(N_CH); c++) begin
        for (int b = 0; b < int'(NBYTES); b++) begin
          if (wr_addr_i == ADDR_W'(int'(ADDR_OCR_BASE) + c * int'(NBYTES) + b))
            ocr_q[c][b*8 +: 8] <= wr_data_i;
        end
      end
    end
  end

  assign com_o  = {com_b_q, com_a_q};
  assign wgm_o  = {wgm_hi_q, wgm_lo_q};
  assign div8_o = div8_q;
  assign ocr_o  = ocr_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_sel_i,
  output logic tick_o
);
  localparam int unsigned PW = $clog2(DIV);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pre_q <= '0;
    else if (pre_q == PW'(DIV - 1)) pre_q <= '0;
    else                            pre_q <= pre_q + 1'b1;
  end

  assign tick_o = !div_sel_i || (pre_q == PW'(DIV - 1));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctc_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= tick_i && !ctc_i && (cnt_q == MAXV);
      if (tick_i) begin
        if (ctc_i && (cnt_q == top_i)) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ocr_i,
  input  com_e             com_i,
  input  logic             port_out_i,
  output logic             level_o,
  output logic             pin_o
);
  logic lvl_q;
  logic hit;

  assign hit = tick_i && (cnt_i == ocr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else if (hit) begin
      case (com_i)
        COM_TOGGLE: lvl_q <= ~lvl_q;
        COM_CLEAR:  lvl_q <= 1'b0;
        COM_SET:    lvl_q <= 1'b1;
        default:    lvl_q <= lvl_q;
      endcase
    end
  end

  assign level_o = lvl_q;
  assign pin_o   = (com_i != COM_OFF) ? lvl_q : port_out_i;
endmodule

// File: rtl/tmr_cmp_wave.sv
module tmr_cmp_wave
  import tmr_cmp_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DIV    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [1:0]        port_out_i,
  input  logic [1:0]        port_dir_i,
  output logic [1:0]        pin_o,
  output logic [1:0]        pin_oe_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  logic [N_CH-1:0][1:0]       com;
  logic [3:0]                 wgm;
  logic                       div8;
  logic [N_CH-1:0][CNT_W-1:0] ocr;
  logic                       tick;
  logic                       ctc;
  logic [N_CH-1:0]            level;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .com_o     (com),
    .wgm_o     (wgm),
    .div8_o    (div8),
    .ocr_o     (ocr)
  );

  tmr_prescaler #(.DIV(DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_sel_i (div8),
    .tick_o    (tick)
  );

  // only one code clears on channel A; all others run free
  assign ctc = (wgm == WGM_CTC);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .ctc_i  (ctc),
    .top_i  (ocr[0]),
    .cnt_o  (cnt_o),
    .ovf_o  (ovf_o)
  );

  for (genvar c = 0; c < int'(N_CH); c++) begin : g_ch
    tmr_cmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .cnt_i      (cnt_o),
      .ocr_i      (ocr[c]),
      .com_i      (com_e'(com[c])),
      .port_out_i (port_out_i[c]),
      .level_o    (level[c]),
      .pin_o      (pin_o[c])
    );
  end

  assign pin_oe_o = port_dir_i;
endmodule

// File: rtl/tmr_cmp_wave_chk.sv
module tmr_cmp_wave_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             ctc_i,
  input logic [CNT_W-1:0] ocr_a_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ovf_i,
  input logic [1:0]       oc_i
);
  // R3
  ovf_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |-> (cnt_i == '0));

  // R3
  ovf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> !ovf_i);

  // R3
  ctc_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctc_i |=> !ovf_i);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ((cnt_i == CNT_W'($past(cnt_i) + 1'b1)) || (cnt_i == '0)));

  // R4
  ctc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ctc_i && (cnt_i == ocr_a_i)) |=> (cnt_i == '0));

  // R8
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(oc_i));
endmodule

bind tmr_cmp_wave tmr_cmp_wave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick),
  .ctc_i   (ctc),
  .ocr_a_i (ocr[0]),
  .cnt_i   (cnt_o),
  .ovf_i   (ovf_o),
  .oc_i    (level)
);

// File: tb/tmr_cmp_wave_tb_top.sv
module tmr_cmp_wave_tb_top;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [1:0]        port_out = 2'b10;
  logic [1:0]        port_dir = 2'b11;
  logic [1:0]        pin;
  logic [1:0]        pin_oe;
  logic [CNT_W-1:0]  cnt;
  logic              ovf;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int ovf_seen = 0;
  bit live = 1'b0;

  always #5 clk = ~clk;

  tmr_cmp_wave #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .port_out_i (port_out),
    .port_dir_i (port_dir),
    .pin_o      (pin),
    .pin_oe_o   (pin_oe),
    .cnt_o      (cnt),
    .ovf_o      (ovf)
  );

  // behavioural reference
  int m_ctrl_a, m_ctrl_b, m_pre, m_cnt, m_ovf;
  int m_ocr[2];
  int m_lvl[2];

  function automatic int m_mode(input int ch);
    return (ch == 0) ? ((m_ctrl_a >> 6) & 3) : ((m_ctrl_a >> 4) & 3);
  endfunction

  function automatic int m_pin(input int ch);
    return (m_mode(ch) != 0) ? m_lvl[ch] : int'(port_out[ch]);
  endfunction

  always @(posedge clk) begin : ref_model
    bit tk, ctc;
    if (!rst_n) begin
      m_ctrl_a = 0; m_ctrl_b = 0; m_pre = 0; m_cnt = 0; m_ovf = 0;
      m_ocr[0] = 0; m_ocr[1] = 0; m_lvl[0] = 0; m_lvl[1] = 0;
    end else begin
      tk  = ((m_ctrl_b & 1) == 0) || (m_pre == 7);
      ctc = ((((m_ctrl_b >> 1) & 3) << 2) | (m_ctrl_a & 3)) == 4;
      if (tk) begin
        for (int ch = 0; ch < 2; ch++) begin
          if (m_cnt == m_ocr[ch]) begin
            case (m_mode(ch))
              1: m_lvl[ch] = 1 - m_lvl[ch];
              2: m_lvl[ch] = 0;
              3: m_lvl[ch] = 1;
              default: ;
            endcase
          end
        end
      end
      m_ovf = (tk && !ctc && m_cnt == 65535) ? 1 : 0;
      if (tk) m_cnt = (ctc && m_cnt == m_ocr[0]) ? 0 : (m_cnt + 1) % 65536;
      m_pre = (m_pre + 1) % 8;
      if (wr_en) begin
        case (int'(wr_addr))
          0: m_ctrl_a = int'(wr_data) & 8'hF3;
          1: m_ctrl_b = int'(wr_data) & 7;
          2: m_ocr[0] = (m_ocr[0] & 16'hFF00) | int'(wr_data);
          3: m_ocr[0] = (m_ocr[0] & 16'h00FF) | (int'(wr_data) << 8);
          4: m_ocr[1] = (m_ocr[1] & 16'hFF00) | int'(wr_data);
          5: m_ocr[1] = (m_ocr[1] & 16'h00FF) | (int'(wr_data) << 8);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (live && rst_n) begin
      check(int'(cnt) == m_cnt, "R2 count", int'(cnt), m_cnt);
      check(int'(ovf) == m_ovf, "R3 overflow", int'(ovf), m_ovf);
      for (int ch = 0; ch < 2; ch++)
        check(int'(pin[ch]) == m_pin(ch), "R9 pin", int'(pin[ch]), m_pin(ch));
      check(pin_oe == port_dir, "R9 enable", int'(pin_oe), int'(port_dir));
      if (ovf) ovf_seen++;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
    @(posedge clk); #2;
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_port(input logic [1:0] o, input logic [1:0] d);
    @(posedge clk); #2;
    port_out = o; port_dir = d;
    @(negedge clk);
  endtask

  task automatic wait_cnt(input int v);
    int n = 0;
    while (int'(cnt) != v && n < 70000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c0, p1;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(cnt == '0, "R1 count", int'(cnt), 0);
    check(ovf == 1'b0, "R1 overflow", int'(ovf), 0);
    check(pin == 2'b10, "R1 pin", int'(pin), 2);
    rst_n = 1'b1;
    live  = 1'b1;
    @(negedge clk);

    // R2 one step per clock
    c0 = int'(cnt);
    idle(10);
    check(int'(cnt) == c0 + 10, "R2 div1", int'(cnt), c0 + 10);

    // R11 R4 clear-on-match, A toggles at 20, B sets at 10
    wr(2, 20); wr(3, 0); wr(4, 10); wr(5, 0);
    wr(1, 8'h02);
    wr(0, 8'h70);
    wait_cnt(20);
    @(negedge clk);
    check(cnt == '0, "R4 clear", int'(cnt), 0);

    // R5 toggle per period
    wait_cnt(5);
    p1 = int'(pin[0]);
    @(negedge clk);
    wait_cnt(5);
    check(int'(pin[0]) == 1 - p1, "R5 toggle", int'(pin[0]), 1 - p1);
    // R6 set
    check(pin[1] == 1'b1, "R6 set", int'(pin[1]), 1);

    // R6 clear; R8 level held just after write
    wait_cnt(12);
    wr(0, 8'h60);
    check(pin[1] == 1'b1, "R8 held", int'(pin[1]), 1);
    wait_cnt(11);
    check(pin[1] == 1'b0, "R6 clear", int'(pin[1]), 0);

    // R7 disconnected: set level to 1 first, then mode 00 across matches
    wr(0, 8'h70);
    wait_cnt(11);
    wr(0, 8'h40);
    set_port(2'b00, 2'b11);
    check(pin[1] == 1'b0, "R7 port low", int'(pin[1]), 0);
    set_port(2'b10, 2'b11);
    check(pin[1] == 1'b1, "R7 port high", int'(pin[1]), 1);
    set_port(2'b00, 2'b11);
    idle(70);
    wait_cnt(13);
    wr(0, 8'h50);
    check(pin[1] == 1'b1, "R7 level kept", int'(pin[1]), 1);

    // R9 override and enable
    set_port(2'b11, 2'b01);
    check(pin_oe == 2'b01, "R9 enable", int'(pin_oe), 1);
    wr(0, 8'h20);
    wait_cnt(11);
    check(pin[1] == 1'b0, "R9 override", int'(pin[1]), 0);

    // coincident: B equals A in clear-on-match
    wr(4, 20);
    wr(0, 8'h50);
    idle(100);

    // R10 other waveform code runs free
    wr(0, 8'h51);
    wait_cnt(20);
    @(negedge clk);
    check(int'(cnt) == 21, "R10 no clear", int'(cnt), 21);

    // R2 divide by eight, free-running
    wr(1, 8'h01);
    wr(0, 8'h00);
    c0 = int'(cnt);
    idle(80);
    check(int'(cnt) == c0 + 10, "R2 div8", int'(cnt), c0 + 10);

    // R3 wrap with both matches at the top value
    wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
    wr(1, 8'h00);
    wr(0, 8'h70);
    ovf_seen = 0;
    while (!ovf && cyc < 180000) @(negedge clk);
    check(ovf == 1'b1, "R3 strobe", int'(ovf), 1);
    check(cnt == '0, "R3 wrap", int'(cnt), 0);
    @(negedge clk);
    check(ovf == 1'b0, "R3 single", int'(ovf), 0);
    check(ovf_seen == 1, "R3 count", ovf_seen, 1);
    idle(5);
    finish_run();
  end
endmodule